// File: doc/BRIEF.md
# Relative Branch Target Unit

This combinational unit takes the address of a branch instruction, its first two opcode bytes, an offset field and the zero flag, and produces the next program counter. It handles three branches. The first is an always-taken short branch with a signed 8-bit displacement. The second is an always-taken long branch with a 16-bit displacement. The third is a long branch taken only when the zero flag is set. The unit also reports whether the branch is taken, how long the instruction is in bytes, and whether it recognised the opcode at all.

The displacement is added to the address of the byte after the whole instruction, not to the address of the opcode. A short branch is two bytes long, so its base is PC+2. A long branch starts with a prefix byte and is four bytes long, so its base is PC+4. A fetch or sequencing stage can use `next_pc_o` directly. All address arithmetic is 16-bit and wraps.

Top module: `brt_unit`

## Requirements
- R1: With `op0_i` = 0x20 the unit sets `valid_o`=1, `taken_o`=1, `len_o`=2 and `next_pc_o` = `pc_i` + 2 + sign-extended `off_i[7:0]`.
- R2: A short displacement with bit 7 set moves backwards: an offset of 0xC7 gives `next_pc_o` = `pc_i` + 2 − 0x39.
- R3: With `op0_i` = 0x18 and `op1_i` = 0x20 the unit sets `valid_o`=1, `taken_o`=1, `len_o`=4 and `next_pc_o` = `pc_i` + 4 + `off_i`.
- R4: With `op0_i` = 0x18, `op1_i` = 0x27 and `z_i`=1 the unit sets `valid_o`=1, `taken_o`=1, `len_o`=4 and `next_pc_o` = `pc_i` + 4 + `off_i`.
- R5: With `op0_i` = 0x18, `op1_i` = 0x27 and `z_i`=0 the unit sets `valid_o`=1, `taken_o`=0, `len_o`=4 and `next_pc_o` = `pc_i` + 4.
- R6: Every address sum wraps modulo 2^16. For example, a long branch at 0xFFF0 with offset 0x0020 reaches 0x0014.
- R7: Any other opcode sets `valid_o`=0, `taken_o`=0, `len_o`=2 and `next_pc_o` = `pc_i` + 2. This includes a 0x18 prefix followed by a second byte other than 0x20 or 0x27.
- R8: For the short branch, `off_i[15:8]`, `op1_i` and `z_i` have no effect on any output. For the always-taken long branch, `z_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 16 | Address of the branch opcode |
| op0_i | input | 8 | First opcode byte |
| op1_i | input | 8 | Second opcode byte (used only after the 0x18 prefix) |
| off_i | input | 16 | Displacement; short branches use bits 7:0 only |
| z_i | input | 1 | Zero flag |
| next_pc_o | output | 16 | Next program counter |
| taken_o | output | 1 | Branch taken |
| len_o | output | 3 | Instruction length in bytes |
| valid_o | output | 1 | Opcode recognised |

## Verification
The bench targets the base-address rule by using short and long branches at the same PC. A design that added the offset to PC, or used the wrong length, would miss by 2 or 4. Backward short offsets such as 0xC7 catch a displacement that is zero-extended instead of sign-extended. Stray upper offset bits on short branches catch a design that reads all 16 bits.

Branches placed near 0xFFFF show whether sums wrap correctly. The equal branch with Z clear and prefixed unknown opcodes check that the fall-through address and length are right when nothing is taken. Random mixes over all classes then compare every output with a reference model computed in the bench.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam logic [7:0] OP_PREFIX = 8'h18;
  localparam logic [7:0] OP_BRA    = 8'h20;
  localparam logic [7:0] OP_BEQ    = 8'h27;
  localparam int unsigned LEN_W    = 3;
  localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
  localparam logic [LEN_W-1:0] LEN_LONG  = 3'd4;

  typedef enum logic [1:0] {
    BK_NONE,
    BK_SHORT,
    BK_LONG,
    BK_LONG_EQ
  } br_kind_e;
endpackage

// File: rtl/brt_decode.sv
module brt_decode
  import brt_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] op0_i,
  input  logic [BYTE_W-1:0] op1_i,
  output br_kind_e          kind_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              valid_o
);
  always_comb begin
    kind_o = BK_NONE;
    if (op0_i == OP_BRA) kind_o = BK_SHORT;
    else if (op0_i == OP_PREFIX) begin
      if (op1_i == OP_BRA)      kind_o = BK_LONG;
      else if (op1_i == OP_BEQ) kind_o = BK_LONG_EQ;
    end
  end

  assign valid_o = (kind_o != BK_NONE);
  assign len_o   = (kind_o == BK_LONG || kind_o == BK_LONG_EQ) ? LEN_LONG : LEN_SHORT;

  // unknown opcodes fall through as two-byte instructions
  always_comb begin
    if (!valid_o) p_invalid_len_r7: assert (len_o == LEN_SHORT) else $error("len on invalid");
  end
endmodule

// File: rtl/brt_cond.sv
module brt_cond
  import brt_pkg::*;
(
  input  br_kind_e kind_i,
  input  logic     z_i,
  output logic     taken_o
);
  always_comb begin
    unique case (kind_i)
      BK_SHORT, BK_LONG: taken_o = 1'b1;
      BK_LONG_EQ:        taken_o = z_i;
      default:           taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brt_target.sv
module brt_target
  import brt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned LONG_W  = 16
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LONG_W-1:0] off_i,
  input  logic              long_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] target_o
);
  logic [ADDR_W-1:0] off_short, off_long, off_sel, diff;

  assign off_short = {{(ADDR_W-SHORT_W){off_i[SHORT_W-1]}}, off_i[SHORT_W-1:0]};

  generate
    if (LONG_W < ADDR_W) begin : g_long_ext
      assign off_long = {{(ADDR_W-LONG_W){1'b0}}, off_i};
    end else begin : g_long_cut
      assign off_long = off_i[ADDR_W-1:0];
    end
  endgenerate

  assign off_sel  = long_i ? off_long : off_short;
  assign base_o   = pc_i + ADDR_W'(len_i);
  assign target_o = base_o + off_sel;   // wraps modulo 2^ADDR_W
  assign diff     = target_o - base_o;

  // short reach must stay inside a signed byte around the base
  always_comb begin
    if (!long_i)
      p_short_reach_r2: assert (diff[ADDR_W-1:SHORT_W-1] == '0 || diff[ADDR_W-1:SHORT_W-1] == '1)
        else $error("short reach");
  end
endmodule

// File: rtl/brt_unit.sv
module brt_unit
  import brt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned LONG_W  = 16
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] op0_i,
  input  logic [BYTE_W-1:0] op1_i,
  input  logic [LONG_W-1:0] off_i,
  input  logic              z_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              valid_o
);
  br_kind_e          kind;
  logic [ADDR_W-1:0] base, target;

  brt_decode #(.BYTE_W(BYTE_W)) u_dec (
    .op0_i(op0_i), .op1_i(op1_i), .kind_o(kind), .len_o(len_o), .valid_o(valid_o)
  );

  brt_cond u_cond (.kind_i(kind), .z_i(z_i), .taken_o(taken_o));

  brt_target #(.ADDR_W(ADDR_W), .SHORT_W(BYTE_W), .LONG_W(LONG_W)) u_tgt (
    .pc_i(pc_i), .len_i(len_o), .off_i(off_i),
    .long_i(kind == BK_LONG || kind == BK_LONG_EQ),
    .base_o(base), .target_o(target)
  );

  assign next_pc_o = taken_o ? target : base;

  always_comb begin
    p_taken_valid_r7: assert (!taken_o || valid_o) else $error("taken on invalid");
    p_len_legal_r3: assert (len_o == LEN_SHORT || len_o == LEN_LONG) else $error("len");
    if (!taken_o)
      p_fallthrough_r5: assert (next_pc_o == pc_i + ADDR_W'(len_o)) else $error("fallthrough");
  end
endmodule

// File: tb/tb_brt_unit.sv
module tb_brt_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] pc, off, next_pc;
  logic [7:0]  op0, op1;
  logic        z, taken, valid;
  logic [2:0]  len;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  brt_unit dut (
    .pc_i(pc), .op0_i(op0), .op1_i(op1), .off_i(off), .z_i(z),
    .next_pc_o(next_pc), .taken_o(taken), .len_o(len), .valid_o(valid)
  );

  function automatic logic [21:0] model(input logic [15:0] p, input logic [7:0] a,
                                        input logic [7:0] b, input logic [15:0] o,
                                        input logic zf);
    logic [15:0] np; logic tk, vl; logic [2:0] ln;
    if (a == 8'h20) begin
      vl = 1; tk = 1; ln = 2; np = p + 16'd2 + {{8{o[7]}}, o[7:0]};
    end else if (a == 8'h18 && (b == 8'h20 || b == 8'h27)) begin
      vl = 1; ln = 4; tk = (b == 8'h20) ? 1'b1 : zf;
      np = tk ? p + 16'd4 + o : p + 16'd4;
    end else begin
      vl = 0; tk = 0; ln = 2; np = p + 16'd2;
    end
    return {np, tk, ln, vl, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp,
                     input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] p, input logic [7:0] a,
                       input logic [7:0] b, input logic [15:0] o, input logic zf);
    logic [21:0] e;
    @(posedge clk);
    pc = p; op0 = a; op1 = b; off = o; z = zf;
    @(negedge clk);
    e = model(p, a, b, o, zf);
    chk(tag, next_pc, e[21:6], "next_pc");
    chk(tag, {15'd0, taken}, {15'd0, e[5]}, "taken");
    chk(tag, {13'd0, len}, {13'd0, e[4:2]}, "len");
    chk(tag, {15'd0, valid}, {15'd0, e[1]}, "valid");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] r0;
    logic [7:0] a, b;
    pc = 0; op0 = 0; op1 = 0; off = 0; z = 0;
    void'($urandom(32'd4242));
    // R1 forward short branch
    apply("R1", 16'h1020, 8'h20, 8'h00, 16'h000E, 1'b0);
    chk("R1", next_pc, 16'h1030, "direct target");
    // R2 backward short branch
    apply("R2", 16'h1000, 8'h20, 8'h00, 16'h00C7, 1'b0);
    chk("R2", next_pc, 16'h1000 + 16'd2 - 16'h0039, "backward target");
    // R3 long always
    apply("R3", 16'h1000, 8'h18, 8'h20, 16'h0ECF, 1'b0);
    chk("R3", next_pc, 16'h1ED3, "long target");
    // R4 / R5 long on equal
    apply("R4", 16'h2000, 8'h18, 8'h27, 16'h021A, 1'b1);
    chk("R4", next_pc, 16'h221E, "beq taken");
    apply("R5", 16'h2000, 8'h18, 8'h27, 16'h021A, 1'b0);
    chk("R5", next_pc, 16'h2004, "beq fallthrough");
    // R6 wrap
    apply("R6", 16'hFFF0, 8'h18, 8'h20, 16'h0020, 1'b0);
    chk("R6", next_pc, 16'h0014, "long wrap");
    apply("R6", 16'hFFFF, 8'h20, 8'h00, 16'h0010, 1'b0);
    chk("R6", next_pc, 16'h0011, "short wrap");
    apply("R6", 16'h0002, 8'h20, 8'h00, 16'h0080, 1'b0);
    chk("R6", next_pc, 16'hFF84, "short underflow");
    // R7 unknown opcodes
    apply("R7", 16'h3000, 8'h86, 8'h20, 16'h1234, 1'b1);
    apply("R7", 16'hFFFF, 8'h18, 8'h06, 16'h1234, 1'b1);
    chk("R7", next_pc, 16'h0001, "prefixed unknown");
    // R8 ignored inputs
    apply("R8", 16'h4000, 8'h20, 8'h00, 16'h0005, 1'b0);
    r0 = next_pc;
    apply("R8", 16'h4000, 8'h20, 8'h27, 16'hAB05, 1'b1);
    chk("R8", next_pc, r0, "short ignores hi off/op1/z");
    apply("R8", 16'h4000, 8'h18, 8'h20, 16'h8000, 1'b0);
    r0 = next_pc;
    apply("R8", 16'h4000, 8'h18, 8'h20, 16'h8000, 1'b1);
    chk("R8", next_pc, r0, "long always ignores z");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int cls;
      cls = $urandom % 5;
      a = $urandom; b = $urandom;
      case (cls)
        0: begin a = 8'h20; apply("R1", $urandom, a, b, $urandom, $urandom); end
        1: begin a = 8'h18; b = 8'h20; apply("R3", $urandom, a, b, $urandom, $urandom); end
        2: begin a = 8'h18; b = 8'h27; apply("R4", $urandom, a, b, $urandom, $urandom); end
        3: begin
          while (a == 8'h20 || a == 8'h18) a = $urandom;
          apply("R7", $urandom, a, b, $urandom, $urandom);
        end
        default: begin
          a = 8'h18;
          while (b == 8'h20 || b == 8'h27) b = $urandom;
          apply("R7", $urandom, a, b, $urandom, $urandom);
        end
      endcase
    end
    finish_run();
  end
endmodule